// File: doc/BRIEF.md
# DMA Address Generator with Megabyte Crossing

This block produces the running source or destination byte address for a single DMA job over a 28-bit address space. The address is split into a megabyte selector in bits 27:20 and an offset in bits 19:0. The block keeps a 36-bit fixed-point accumulator: 28 integer bits and 8 fractional bits. On each step strobe, the accumulator moves up or down by a fractional step that was captured when the job was loaded.

A policy decides what happens when the offset runs past either end of its megabyte. By default the selector stays fixed, and the offset wraps inside the current megabyte. Crossing lets a carry or borrow reach the selector. Crossing is allowed when either of these is set, provided the hypervisor-mode input is low:
- a global enable bit in a small control register;
- a per-job option.

Hypervisor mode always forces wrapping. The control register also holds an independent job-format override bit. Each bit is written through a per-bit mask, so writing one bit leaves the other alone.

The crossing decision, the step and the direction are all latched at job load. They then hold for the rest of the job, so later register writes or mode changes have no effect on a job already in flight.

Top module: `dma_addr_gen`

## Requirements
- R1: While rst_n is low at a clock edge, the address, the latched crossing flag and both control bits become 0 after that edge.
- R2: A job load sets the address to job_start with the fractional part cleared, from the next cycle.
- R3: A step strobe in an upward job adds the latched step to the accumulator. The step has 8 fractional bits, so a step of 0x0080 (one half) moves the address by one byte every two strobes. The address output is the integer part.
- R4: A step strobe in a downward job (job_down=1 at load) subtracts the latched step.
- R5: With neither job load nor step strobe asserted, the address does not change.
- R6: In wrap mode, bits 27:20 stay constant, and bits 19:0 together with the fraction wrap modulo 2^20 bytes. For example, 0x01FFFFF plus 1.0 gives 0x0100000.
- R7: In crossing mode, a carry or borrow reaches bits 27:20, and the whole address wraps modulo 2^28. For example, 0x01FFFFF plus 1 gives 0x0200000, and 0x0000000 minus 1 gives 0xFFFFFFF.
- R8: Control bit 1 (ctrl_cross_en) enables crossing for a job loaded without the per-job option.
- R9: The per-job option (job_cross_opt=1) enables crossing for that job while the global bit is 0.
- R10: A job loaded while hyper_mode=1 always wraps, whatever the global bit and the per-job option are.
- R11: A register write updates only the control bits whose reg_wr_mask bit is 1: mask bit 0 selects the format bit, and mask bit 1 selects the crossing bit. Unmasked bits keep their value.
- R12: The crossing decision, step and direction are sampled at load from the values before that edge, and held. Writes to the control register and changes of hyper_mode during the job have no effect on its stepping.
- R13: A job load and a step strobe in the same cycle act as a load alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Control register write enable |
| reg_wr_mask | input | 2 | Per-bit write select (bit 0 format, bit 1 crossing) |
| reg_wr_data | input | 2 | Control write data |
| hyper_mode | input | 1 | Hypervisor mode active |
| job_load | input | 1 | Load a new job |
| job_start | input | 28 | Job start address |
| job_step | input | 16 | Fractional step, 8 fractional bits |
| job_down | input | 1 | 1 means the address counts down |
| job_cross_opt | input | 1 | Per-job crossing option |
| step_stb | input | 1 | Advance the address by one step |
| addr_out | output | 28 | Current byte address |
| cross_active | output | 1 | Latched crossing decision of the current job |
| ctrl_fmt_b | output | 1 | Global job-format override bit (control bit 0) |
| ctrl_cross_en | output | 1 | Global crossing enable (control bit 1) |

## Verification
The bench builds the block with its default parameters:
- a 28-bit address with 8 fractional bits;
- a 20-bit offset, which puts megabyte boundaries every 0x100000 bytes;
- a 16-bit step.

With these values, jobs started a few bytes below a boundary reach wrap and crossing within a handful of strobes. The very top and bottom of the 28-bit space are reached from 0xFFFFFFF and 0. The 8-bit fraction makes half-byte and three-quarter-byte steps observable within a few cycles.

// File: rtl/dma_addr_pkg.sv
// Shared types for the DMA address generator.
// Assumes a two-bit control register: bit 0 format override, bit 1 crossing enable.
package dma_addr_pkg;
    localparam int CTRL_W = 2;
    localparam int CTRL_FMT_BIT = 0;
    localparam int CTRL_CROSS_BIT = 1;

    typedef struct packed {
        logic cross_en;
        logic fmt_b;
    } ctrl_t;
endpackage

// File: rtl/dma_ctrl_reg.sv
// Global control register with per-bit masked writes.
// Assumes only the bits selected by the mask change on a write.
module dma_ctrl_reg
    import dma_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_mask,
    input  logic [CTRL_W-1:0] wr_data,
    output ctrl_t             ctrl_q
);
    logic [CTRL_W-1:0] bits_q;

    genvar gi;
    generate
        for (gi = 0; gi < CTRL_W; gi++) begin : g_bit
            // Update one control bit when its mask bit is set.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    bits_q[gi] <= 1'b0;
                else if (wr_en && wr_mask[gi])
                    bits_q[gi] <= wr_data[gi];
            end
        end
    endgenerate

    assign ctrl_q = ctrl_t'(bits_q);
endmodule

// File: rtl/dma_cross_policy.sv
// Decides whether a job being loaded may cross megabyte boundaries.
// Assumes hypervisor mode overrides every enable.
module dma_cross_policy (
    input  logic glob_en,
    input  logic job_opt,
    input  logic hyper,
    output logic cross_ok
);
    // Either enable source, vetoed by hypervisor mode.
    always_comb cross_ok = !hyper && (glob_en || job_opt);
endmodule

// File: rtl/dma_addr_accum.sv
// Fixed-point address accumulator with wrap or cross behaviour.
// Assumes OFFS_W < ADDR_W and a step narrower than the accumulator.
module dma_addr_accum #(
    parameter int ADDR_W = 28,
    parameter int FRAC_W = 8,
    parameter int OFFS_W = 20,
    parameter int STEP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] start,
    input  logic [STEP_W-1:0] step,
    input  logic              down,
    input  logic              cross_ok,
    input  logic              adv,
    output logic [ADDR_W-1:0] addr,
    output logic              cross_q
);
    localparam int ACC_W = ADDR_W + FRAC_W;
    localparam int LOW_W = OFFS_W + FRAC_W;

    logic [ACC_W-1:0]  acc_q;
    logic [STEP_W-1:0] step_q;
    logic              down_q;
    logic [ACC_W-1:0]  step_ext;
    logic [ACC_W-1:0]  sum;
    logic [ACC_W-1:0]  nxt;

    assign step_ext = ACC_W'(step_q);

    // Next accumulator value: full sum or sum confined to the megabyte.
    always_comb begin
        sum = down_q ? (acc_q - step_ext) : (acc_q + step_ext);
        nxt = cross_q ? sum : {acc_q[ACC_W-1:LOW_W], sum[LOW_W-1:0]};
    end

    // Job state: load has priority over a step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            step_q  <= '0;
            down_q  <= 1'b0;
            cross_q <= 1'b0;
        end else if (load) begin
            acc_q   <= {start, {FRAC_W{1'b0}}};
            step_q  <= step;
            down_q  <= down;
            cross_q <= cross_ok;
        end else if (adv) begin
            acc_q   <= nxt;
        end
    end

    assign addr = acc_q[ACC_W-1:FRAC_W];
endmodule

// File: rtl/dma_addr_gen.sv
// Top of the DMA address generator: control register, policy and accumulator.
// Assumes register writes and job loads are single-cycle strobes.
module dma_addr_gen
    import dma_addr_pkg::*;
#(
    parameter int ADDR_W = 28,
    parameter int FRAC_W = 8,
    parameter int OFFS_W = 20,
    parameter int STEP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_wr_mask,
    input  logic [1:0]        reg_wr_data,
    input  logic              hyper_mode,
    input  logic              job_load,
    input  logic [ADDR_W-1:0] job_start,
    input  logic [STEP_W-1:0] job_step,
    input  logic              job_down,
    input  logic              job_cross_opt,
    input  logic              step_stb,
    output logic [ADDR_W-1:0] addr_out,
    output logic              cross_active,
    output logic              ctrl_fmt_b,
    output logic              ctrl_cross_en
);
    ctrl_t ctrl;
    logic  cross_ok;

    dma_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wr_mask (reg_wr_mask),
        .wr_data (reg_wr_data),
        .ctrl_q  (ctrl)
    );

    dma_cross_policy u_policy (
        .glob_en  (ctrl.cross_en),
        .job_opt  (job_cross_opt),
        .hyper    (hyper_mode),
        .cross_ok (cross_ok)
    );

    dma_addr_accum #(
        .ADDR_W (ADDR_W),
        .FRAC_W (FRAC_W),
        .OFFS_W (OFFS_W),
        .STEP_W (STEP_W)
    ) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (job_load),
        .start    (job_start),
        .step     (job_step),
        .down     (job_down),
        .cross_ok (cross_ok),
        .adv      (step_stb),
        .addr     (addr_out),
        .cross_q  (cross_active)
    );

    assign ctrl_fmt_b    = ctrl.fmt_b;
    assign ctrl_cross_en = ctrl.cross_en;
endmodule

// File: rtl/dma_addr_gen_chk.sv
// Property checker for dma_addr_gen, attached by bind.
// Assumes the default split of selector bits above OFFS_W.
module dma_addr_gen_chk #(
    parameter int ADDR_W = 28,
    parameter int OFFS_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              job_load,
    input logic [ADDR_W-1:0] job_start,
    input logic              hyper_mode,
    input logic              step_stb,
    input logic              reg_wr_en,
    input logic [1:0]        reg_wr_mask,
    input logic [ADDR_W-1:0] addr_out,
    input logic              cross_active,
    input logic              ctrl_fmt_b,
    input logic              ctrl_cross_en
);
    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (addr_out == '0 && !cross_active && !ctrl_fmt_b && !ctrl_cross_en));

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        job_load |=> addr_out == $past(job_start));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!job_load && !step_stb) |=> $stable(addr_out));

    assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!job_load && step_stb && !cross_active)
        |=> addr_out[ADDR_W-1:OFFS_W] == $past(addr_out[ADDR_W-1:OFFS_W]));

    assert_hyper_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (job_load && hyper_mode) |=> !cross_active);

    assert_fmt_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && !reg_wr_mask[0]) |=> $stable(ctrl_fmt_b));

    assert_cross_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && !reg_wr_mask[1]) |=> $stable(ctrl_cross_en));

    assert_policy_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !job_load |=> $stable(cross_active));
endmodule

bind dma_addr_gen dma_addr_gen_chk #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .job_load      (job_load),
    .job_start     (job_start),
    .hyper_mode    (hyper_mode),
    .step_stb      (step_stb),
    .reg_wr_en     (reg_wr_en),
    .reg_wr_mask   (reg_wr_mask),
    .addr_out      (addr_out),
    .cross_active  (cross_active),
    .ctrl_fmt_b    (ctrl_fmt_b),
    .ctrl_cross_en (ctrl_cross_en)
);

// File: tb/tb_dma_addr_gen.sv
// Bench for dma_addr_gen: behavioural reference compared every clock plus corner checks.
module tb_dma_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_wr_mask = 2'b00;
    logic [1:0]  reg_wr_data = 2'b00;
    logic        hyper_mode = 1'b0;
    logic        job_load = 1'b0;
    logic [27:0] job_start = '0;
    logic [15:0] job_step = '0;
    logic        job_down = 1'b0;
    logic        job_cross_opt = 1'b0;
    logic        step_stb = 1'b0;
    logic [27:0] addr_out;
    logic        cross_active;
    logic        ctrl_fmt_b;
    logic        ctrl_cross_en;

    int    total = 0;
    int    bad = 0;
    string cur_tag = "R1";

    longint m_acc = 0;
    longint m_step = 0;
    bit     m_down = 0;
    bit     m_cross = 0;
    bit [1:0] m_ctrl = 2'b00;
    localparam longint ACC_MASK = (64'd1 << 36) - 1;
    localparam longint LOW_MASK = (64'd1 << 28) - 1;

    always #4 clk = ~clk;

    dma_addr_gen dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_mask(reg_wr_mask),
        .reg_wr_data(reg_wr_data), .hyper_mode(hyper_mode), .job_load(job_load),
        .job_start(job_start), .job_step(job_step), .job_down(job_down),
        .job_cross_opt(job_cross_opt), .step_stb(step_stb), .addr_out(addr_out),
        .cross_active(cross_active), .ctrl_fmt_b(ctrl_fmt_b), .ctrl_cross_en(ctrl_cross_en)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference update from the inputs present at the edge.
    task automatic model_edge();
        longint full;
        if (!rst_n) begin
            m_acc = 0; m_step = 0; m_down = 0; m_cross = 0; m_ctrl = 2'b00;
        end else begin
            if (job_load) begin
                m_acc   = longint'(job_start) << 8;
                m_step  = longint'(job_step);
                m_down  = job_down;
                m_cross = !hyper_mode && (job_cross_opt || m_ctrl[1]);
            end else if (step_stb) begin
                full = (m_down ? m_acc - m_step : m_acc + m_step) & ACC_MASK;
                m_acc = m_cross ? full : ((m_acc & ~LOW_MASK) | (full & LOW_MASK));
            end
            if (reg_wr_en)
                m_ctrl = (m_ctrl & ~reg_wr_mask) | (reg_wr_data & reg_wr_mask);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk(cur_tag, longint'(addr_out), m_acc >> 8);
        chk(cur_tag, longint'(cross_active), longint'(m_cross));
        chk(cur_tag, longint'({ctrl_cross_en, ctrl_fmt_b}), longint'(m_ctrl));
    endtask

    task automatic idle_inputs();
        job_load = 0; step_stb = 0; reg_wr_en = 0; reg_wr_mask = 0; reg_wr_data = 0;
    endtask

    task automatic do_load(input logic [27:0] s, input logic [15:0] st,
                           input logic dn, input logic opt);
        job_load = 1; job_start = s; job_step = st; job_down = dn; job_cross_opt = opt;
        tick();
        idle_inputs();
    endtask

    task automatic do_steps(input int n);
        for (int i = 0; i < n; i++) begin
            step_stb = 1;
            tick();
        end
        step_stb = 0;
    endtask

    task automatic do_wr(input logic [1:0] mask, input logic [1:0] data);
        reg_wr_en = 1; reg_wr_mask = mask; reg_wr_data = data;
        tick();
        idle_inputs();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        cur_tag = "R1";
        repeat (3) tick();
        chk("R1", longint'(addr_out), 0);
        chk("R1", longint'({ctrl_cross_en, ctrl_fmt_b, cross_active}), 0);
        rst_n = 1;

        cur_tag = "R2";
        do_load(28'h0123456, 16'h0100, 0, 0);
        chk("R2", longint'(addr_out), 28'h0123456);
        cur_tag = "R5";
        repeat (3) tick();
        chk("R5", longint'(addr_out), 28'h0123456);

        cur_tag = "R6";
        do_load(28'h01FFFFF, 16'h0100, 0, 0);
        do_steps(1);
        chk("R6", longint'(addr_out), 28'h0100000);
        do_load(28'h01FFFF0, 16'h0100, 0, 0);
        do_steps(20);

        cur_tag = "R11";
        do_wr(2'b01, 2'b11);
        chk("R11", longint'({ctrl_cross_en, ctrl_fmt_b}), 2'b01);
        do_wr(2'b10, 2'b10);
        chk("R11", longint'({ctrl_cross_en, ctrl_fmt_b}), 2'b11);
        do_wr(2'b01, 2'b00);
        chk("R11", longint'({ctrl_cross_en, ctrl_fmt_b}), 2'b10);

        cur_tag = "R8";
        do_load(28'h01FFFFF, 16'h0100, 0, 0);
        chk("R8", longint'(cross_active), 1);
        do_steps(1);
        chk("R8", longint'(addr_out), 28'h0200000);

        cur_tag = "R7";
        do_load(28'hFFFFFFF, 16'h0100, 0, 0);
        do_steps(1);
        chk("R7", longint'(addr_out), 0);
        do_load(28'h0000000, 16'h0100, 1, 0);
        do_steps(1);
        chk("R7", longint'(addr_out), 28'hFFFFFFF);

        cur_tag = "R10";
        hyper_mode = 1;
        do_load(28'h02FFFFE, 16'h0100, 0, 1);
        do_steps(3);
        chk("R10", longint'(addr_out), 28'h0200001);
        hyper_mode = 0;

        cur_tag = "R9";
        do_wr(2'b10, 2'b00);
        do_load(28'h04FFFFF, 16'h0100, 0, 1);
        do_steps(1);
        chk("R9", longint'(addr_out), 28'h0500000);

        cur_tag = "R4";
        do_load(28'h0300000, 16'h0100, 1, 1);
        do_steps(1);
        chk("R4", longint'(addr_out), 28'h02FFFFF);
        do_load(28'h0300000, 16'h0100, 1, 0);
        do_steps(1);
        chk("R4", longint'(addr_out), 28'h03FFFFF);

        cur_tag = "R3";
        do_load(28'h0000010, 16'h0080, 0, 0);
        do_steps(1);
        chk("R3", longint'(addr_out), 28'h0000010);
        do_steps(1);
        chk("R3", longint'(addr_out), 28'h0000011);
        do_load(28'h00FFFFF, 16'h00C0, 1, 0);
        do_steps(7);

        cur_tag = "R12";
        do_load(28'h06FFFFC, 16'h0100, 0, 0);
        do_wr(2'b10, 2'b10);
        hyper_mode = 1;
        tick();
        hyper_mode = 0;
        do_steps(6);
        chk("R12", longint'(addr_out), 28'h0600002);

        cur_tag = "R13";
        step_stb = 1;
        do_load(28'h0777777, 16'h0200, 0, 0);
        chk("R13", longint'(addr_out), 28'h0777777);

        cur_tag = "R3";
        for (int j = 0; j < 40; j++) begin
            do_load(28'(32'h0FFFF0 * j + 32'h00FFF0), 16'(j * 97 + 5), j[0], j[1]);
            if (j % 3 == 0) do_wr(2'b10, {j[2], 1'b0});
            do_steps(12);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule